// File: doc/BRIEF.md
# Rotate and Mask Unit

This unit takes a 32-bit source word, rotates it to the left, and then combines the rotated word with a contiguous bit mask. The mask is set by a begin position and an end position. When the begin position is past the end position, the run of ones wraps around the top of the word. There are three rotate modes. In the first, the rotated word is ANDed with the mask. In the second, the rotated word is merged into a destination word under the mask. In the third, the word is rotated right and then masked. The unit also performs logical left, logical right and arithmetic right shifts. The shift or rotate amount comes from a 5-bit immediate or from the low bits of a register operand.

The unit computes its result in combinational logic and captures it in a register. `out_valid` is high for one cycle, one clock after each accepted request. `out_word` keeps its value while no request is presented. Bit positions for the mask use big-end numbering: position 0 is the most significant bit, `out_word[31]`.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst_n` is low, the following clock edge sets `out_valid` to 0 and `out_word` to 0.
- R2: A request with `in_valid`=1 at a clock edge gives `out_valid`=1 after that edge. A cycle with `in_valid`=0 gives `out_valid`=0, and `out_word` keeps its previous value.
- R3: The mask has a one at every position p with `mask_begin` <= p <= `mask_end`, where position p is `out_word[31-p]`. Begin equal to end selects a single bit.
- R4: When `mask_begin` > `mask_end`, the mask has ones at positions `mask_begin` through 31 and at positions 0 through `mask_end`.
- R5: Op code 0 (rotate-and-mask) gives rotl(src, n) AND mask. With n = 0 this is plain masking of the source.
- R6: Op code 1 (rotate-and-insert) takes the rotated bits where the mask is 1 and the `dst_word` bits where the mask is 0.
- R7: Op code 5 (rotate-right-and-mask) gives rotl(src, (32-n) mod 32) AND mask, which is a right rotate by n.
- R8: With `amt_sel`=0 the amount is `amt_imm`. With `amt_sel`=1 rotate modes use only `amt_reg[4:0]`, and the higher bits of `amt_reg` have no effect.
- R9: Op code 2 (logical left shift) and op code 3 (logical right shift) fill vacated bits with 0. The mask and `dst_word` are not used.
- R10: Op code 4 (arithmetic right shift) fills vacated bits with `src_word[31]`.
- R11: For shifts with `amt_sel`=1, the amount is `amt_reg[5:0]`. An amount of 32 to 63 gives all zeros for the logical shifts and 32 copies of the sign bit for the arithmetic shift.
- R12: Op codes 6 and 7 produce a result of 0, which is registered like any other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R5 to R12) |
| src_word | input | 32 | Word to rotate or shift |
| dst_word | input | 32 | Destination word for insert mode |
| amt_imm | input | 5 | Immediate amount |
| amt_reg | input | 32 | Register operand that supplies the amount |
| amt_sel | input | 1 | 0 selects the immediate amount, 1 selects the register amount |
| mask_begin | input | 5 | First mask position (position 0 is the MSB) |
| mask_end | input | 5 | Last mask position (position 0 is the MSB) |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Registered result |

## Verification
Every result is due exactly one clock edge after the request is presented. The bench drives a request just after a falling edge. It then waits for the next falling edge, which lies past the single capturing rising edge, and compares `out_valid` and `out_word` there with a value computed by its own functions. Idle cycles are checked in the same half-cycle-offset way, to confirm that `out_valid` drops and `out_word` holds. The checker relates each result to the request inputs sampled one edge earlier.

// File: rtl/rotmask_pkg.sv
// Shared widths and operation codes for the rotate and mask unit.
// Assumes a power-of-two data width.
package rotmask_pkg;
    localparam int RM_DATA_W = 32;
    localparam int RM_AMT_W  = $clog2(RM_DATA_W);

    typedef enum logic [2:0] {
        OP_ROT_AND  = 3'd0,
        OP_ROT_INS  = 3'd1,
        OP_SHL      = 3'd2,
        OP_SHR      = 3'd3,
        OP_SAR      = 3'd4,
        OP_ROTR_AND = 3'd5
    } rm_op_e;
endpackage

// File: rtl/rotmask_maskgen.sv
// Builds a contiguous mask from a begin and an end position. Position p
// maps to bit DATA_W-1-p (position 0 is the MSB). The run of ones wraps
// around when begin > end. Purely combinational.
module rotmask_maskgen #(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input  logic [AW-1:0]     mb,
    input  logic [AW-1:0]     me,
    output logic [DATA_W-1:0] mask
);
    logic wrap;
    assign wrap = (mb > me);

    // One decision per bit position: inside the run, or inside the wrapped run
    for (genvar p = 0; p < DATA_W; p++) begin : g_pos
        logic ge_b;
        logic le_e;
        assign ge_b = (AW'(p) >= mb);
        assign le_e = (AW'(p) <= me);
        assign mask[DATA_W-1-p] = wrap ? (ge_b | le_e) : (ge_b & le_e);
    end
endmodule

// File: rtl/rotmask_rotator.sv
// Left rotator built as a log-depth barrel: stage s rotates by 2**s
// when bit s of the amount is set. Purely combinational.
module rotmask_rotator #(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AW-1:0]     amt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stg [0:AW];
    assign stg[0] = din;

    // Each stage moves the word by one power of two
    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 2 ** s;
        assign stg[s+1] = amt[s]
            ? {stg[s][DATA_W-1-SH:0], stg[s][DATA_W-1:DATA_W-SH]}
            : stg[s];
    end

    assign dout = stg[AW];
endmodule

// File: rtl/rotmask_shifter.sv
// Logical left, logical right and arithmetic right shifter. The amount has
// one bit more than the index width. Any amount >= DATA_W fully flushes
// the word with the fill value (zero, or the sign bit for arithmetic).
module rotmask_shifter #(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AW:0]       amt,
    input  logic              go_left,
    input  logic              arith,
    output logic [DATA_W-1:0] dout
);
    logic              fill;
    logic [DATA_W-1:0] lstg [0:AW];
    logic [DATA_W-1:0] rstg [0:AW];

    assign fill    = arith & din[DATA_W-1];
    assign lstg[0] = din;
    assign rstg[0] = din;

    // Parallel left and right barrels, one power of two per stage
    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 2 ** s;
        assign lstg[s+1] = amt[s] ? {lstg[s][DATA_W-1-SH:0], {SH{1'b0}}} : lstg[s];
        assign rstg[s+1] = amt[s] ? {{SH{fill}}, rstg[s][DATA_W-1:SH]} : rstg[s];
    end

    // Select the direction and apply the full flush for large amounts
    always_comb begin
        if (amt[AW]) begin
            dout = go_left ? '0 : {DATA_W{fill}};
        end else begin
            dout = go_left ? lstg[AW] : rstg[AW];
        end
    end
endmodule

// File: rtl/rotmask_unit.sv
// Top of the rotate and mask unit. Selects the amount, rotates or shifts
// the source, merges the result with the mask, and registers the result
// with a valid strobe. Latency is one cycle. The result holds when idle.
// Assumes a synchronous, active-low reset.
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int DATA_W = RM_DATA_W,
    localparam int AW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_word,
    input  logic [DATA_W-1:0] dst_word,
    input  logic [AW-1:0]     amt_imm,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic              amt_sel,
    input  logic [AW-1:0]     mask_begin,
    input  logic [AW-1:0]     mask_end,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word
);
    rm_op_e            op_e;
    logic [AW-1:0]     rot_amt;
    logic [AW-1:0]     rot_eff;
    logic [AW:0]       shf_amt;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] result;

    assign op_e = rm_op_e'(op);

    // Pick the amount: the rotate amount uses AW bits, the shift amount AW+1
    always_comb begin
        rot_amt = amt_sel ? amt_reg[AW-1:0] : amt_imm;
        shf_amt = amt_sel ? amt_reg[AW:0] : {1'b0, amt_imm};
    end

    // A right rotate is a left rotate by DATA_W - n, taken modulo the width
    always_comb begin
        if (op_e == OP_ROTR_AND) begin
            rot_eff = '0 - rot_amt;
        end else begin
            rot_eff = rot_amt;
        end
    end

    rotmask_rotator #(.DATA_W(DATA_W)) rot_i (
        .din  (src_word),
        .amt  (rot_eff),
        .dout (rotated)
    );

    rotmask_maskgen #(.DATA_W(DATA_W)) mask_i (
        .mb   (mask_begin),
        .me   (mask_end),
        .mask (mask_w)
    );

    rotmask_shifter #(.DATA_W(DATA_W)) shf_i (
        .din     (src_word),
        .amt     (shf_amt),
        .go_left (op_e == OP_SHL),
        .arith   (op_e == OP_SAR),
        .dout    (shifted)
    );

    // Merge the rotated or shifted word according to the operation
    always_comb begin
        case (op_e)
            OP_ROT_AND, OP_ROTR_AND: result = rotated & mask_w;
            OP_ROT_INS:              result = (rotated & mask_w) | (dst_word & ~mask_w);
            OP_SHL, OP_SHR, OP_SAR:  result = shifted;
            default:                 result = '0;
        endcase
    end

    // Register the strobe every cycle; capture the result only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= result;
            end
        end
    end
endmodule

// File: rtl/rotmask_checker.sv
// Property checker for rotmask_unit, attached with bind. It looks at the
// ports and at the mask built by the mask generator.
module rotmask_checker #(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] dst_word,
    input logic [DATA_W-1:0] amt_reg,
    input logic              amt_sel,
    input logic [AW-1:0]     mask_begin,
    input logic [AW-1:0]     mask_end,
    input logic [DATA_W-1:0] mask_w,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_word
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));

    assert_mask_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_begin <= mask_end) |->
        ($countones(mask_w) == int'(mask_end) - int'(mask_begin) + 1));

    assert_mask_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_begin > mask_end) |->
        ($countones(mask_w) == DATA_W + 1 - int'(mask_begin) + int'(mask_end)));

    assert_and_outside_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> ((out_word & ~$past(mask_w)) == '0));

    assert_insert_keeps_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1) |=> (((out_word ^ $past(dst_word)) & ~$past(mask_w)) == '0));

    assert_big_shift_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd2 || op == 3'd3) && amt_sel && amt_reg[AW]) |=> (out_word == '0));

    assert_unused_op_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> (out_word == '0));
endmodule

bind rotmask_unit rotmask_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .dst_word   (dst_word),
    .amt_reg    (amt_reg),
    .amt_sel    (amt_sel),
    .mask_begin (mask_begin),
    .mask_end   (mask_end),
    .mask_w     (mask_w),
    .out_valid  (out_valid),
    .out_word   (out_word)
);

// File: tb/rotmask_unit_tb.sv
`timescale 1ns/1ps
// Bench for rotmask_unit: directed corner cases, then seeded random
// requests mixed with idle cycles, all checked against bench functions.
module rotmask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_word = '0;
    logic [31:0] dst_word = '0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        amt_sel = 1'b0;
    logic [4:0]  mask_begin = '0;
    logic [4:0]  mask_end = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [31:0] last_word = '0;

    always #4 clk = ~clk;

    rotmask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_word(src_word), .dst_word(dst_word), .amt_imm(amt_imm),
        .amt_reg(amt_reg), .amt_sel(amt_sel), .mask_begin(mask_begin),
        .mask_end(mask_end), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [31:0] f_mask(input int b, input int e);
        logic [31:0] m = '0;
        for (int p = 0; p < 32; p++) begin
            if ((b <= e && p >= b && p <= e) || (b > e && (p >= b || p <= e)))
                m[31-p] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] f_rotl(input logic [31:0] x, input int n);
        int k = n % 32;
        if (k == 0) return x;
        return (x << k) | (x >> (32 - k));
    endfunction

    function automatic logic [31:0] f_expect(
        input logic [2:0] o, input logic [31:0] s, input logic [31:0] d,
        input logic [4:0] imm, input logic [31:0] rg, input logic sel,
        input logic [4:0] b, input logic [4:0] e);
        int rn = sel ? int'(rg[4:0]) : int'(imm);
        int sn = sel ? int'(rg[5:0]) : int'(imm);
        logic [31:0] m = f_mask(int'(b), int'(e));
        case (o)
            3'd0: return f_rotl(s, rn) & m;
            3'd1: return (f_rotl(s, rn) & m) | (d & ~m);
            3'd2: return (sn >= 32) ? 32'h0 : (s << sn);
            3'd3: return (sn >= 32) ? 32'h0 : (s >> sn);
            3'd4: return (sn >= 32) ? {32{s[31]}} : 32'($signed(s) >>> sn);
            3'd5: return f_rotl(s, 32 - rn) & m;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive a request after a falling edge; check it at the next falling edge
    task automatic apply(input string tag, input logic [2:0] o, input logic [31:0] s,
                         input logic [31:0] d, input logic [4:0] imm, input logic [31:0] rg,
                         input logic sel, input logic [4:0] b, input logic [4:0] e);
        logic [31:0] exp = f_expect(o, s, d, imm, rg, sel, b, e);
        in_valid = 1'b1; op = o; src_word = s; dst_word = d; amt_imm = imm;
        amt_reg = rg; amt_sel = sel; mask_begin = b; mask_end = e;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
        check(tag, out_word, exp);
        last_word = exp;
    endtask

    // Idle cycle with changed data: the strobe drops and the result holds
    task automatic idle_cycle();
        in_valid = 1'b0; src_word = $urandom; dst_word = $urandom; op = 3'($urandom);
        @(negedge clk);
        check("R2 idle valid", {31'b0, out_valid}, 32'd0);
        check("R2 idle hold", out_word, last_word);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset word", out_word, 32'h0);
        rst_n = 1'b1;

        // Directed corner cases
        apply("R3 full mask",       3'd0, 32'hDEADBEEF, 0, 5'd0, 0, 0, 5'd0, 5'd31);
        apply("R3 single bit msb",  3'd0, 32'hFFFFFFFF, 0, 5'd0, 0, 0, 5'd0, 5'd0);
        apply("R3 single bit lsb",  3'd0, 32'hFFFFFFFF, 0, 5'd0, 0, 0, 5'd31, 5'd31);
        apply("R3 mid run",         3'd0, 32'hFFFFFFFF, 0, 5'd0, 0, 0, 5'd8, 5'd15);
        apply("R4 wrap",            3'd0, 32'hFFFFFFFF, 0, 5'd0, 0, 0, 5'd28, 5'd3);
        apply("R4 wrap adjacent",   3'd0, 32'hFFFFFFFF, 0, 5'd0, 0, 0, 5'd16, 5'd15);
        apply("R5 rotate by 8",     3'd0, 32'h12345678, 0, 5'd8, 0, 0, 5'd0, 5'd31);
        apply("R5 plain masking",   3'd0, 32'h12345678, 0, 5'd0, 0, 0, 5'd16, 5'd31);
        apply("R6 insert field",    3'd1, 32'h000000AB, 32'h11223344, 5'd16, 0, 0, 5'd8, 5'd15);
        apply("R6 insert wrapped",  3'd1, 32'hF000000F, 32'h5A5A5A5A, 5'd4, 0, 0, 5'd30, 5'd1);
        apply("R7 rotate right 4",  3'd5, 32'h12345678, 0, 5'd4, 0, 0, 5'd0, 5'd31);
        apply("R7 rotate right 0",  3'd5, 32'h12345678, 0, 5'd0, 0, 0, 5'd0, 5'd31);
        apply("R8 reg amount high bits ignored", 3'd0, 32'h80000001, 0, 5'd0, 32'hFFFFFFE3, 1, 5'd0, 5'd31);
        apply("R8 immediate amount", 3'd0, 32'h80000001, 0, 5'd1, 32'h7, 0, 5'd0, 5'd31);
        apply("R9 shift left",      3'd2, 32'h8000000F, 32'hFFFFFFFF, 5'd4, 0, 0, 5'd5, 5'd2);
        apply("R9 shift right",     3'd3, 32'hF0000001, 32'hFFFFFFFF, 5'd4, 0, 0, 5'd5, 5'd2);
        apply("R10 arith negative", 3'd4, 32'h80000010, 0, 5'd4, 0, 0, 5'd0, 5'd0);
        apply("R10 arith positive", 3'd4, 32'h70000010, 0, 5'd31, 0, 0, 5'd0, 5'd0);
        apply("R11 shl 32",         3'd2, 32'hFFFFFFFF, 0, 5'd0, 32'd32, 1, 5'd0, 5'd0);
        apply("R11 shr 63",         3'd3, 32'hFFFFFFFF, 0, 5'd0, 32'd63, 1, 5'd0, 5'd0);
        apply("R11 sar 40 negative", 3'd4, 32'h80000000, 0, 5'd0, 32'd40, 1, 5'd0, 5'd0);
        apply("R11 sar 31 from reg", 3'd4, 32'h80000000, 0, 5'd0, 32'd31, 1, 5'd0, 5'd0);
        apply("R12 op six",         3'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 0, 0, 5'd0, 5'd31);
        apply("R12 op seven",       3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 0, 0, 5'd0, 5'd31);
        idle_cycle();

        // Seeded random requests with occasional idle cycles
        for (int i = 0; i < 400; i++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            string tag;
            case (o)
                3'd0: tag = "R5 random";
                3'd1: tag = "R6 random";
                3'd5: tag = "R7 random";
                3'd4: tag = "R10 random";
                3'd6, 3'd7: tag = "R12 random";
                default: tag = "R9 random";
            endcase
            apply(tag, o, $urandom, $urandom, 5'($urandom), $urandom, 1'($urandom),
                  5'($urandom), 5'($urandom));
            if ($urandom_range(0, 3) == 0) idle_cycle();
        end

        // A request under reset must not survive
        in_valid = 1'b1; op = 3'd0; src_word = 32'hFFFFFFFF; mask_begin = 0; mask_end = 31;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset overrides request valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset overrides request word", out_word, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule